// File: doc/BRIEF.md
# Base Address Window Decoder

This block holds the address-assignment registers of a type-0 configuration header for one endpoint function. There are six base slots, an expansion ROM base register, and a command word that carries the I/O and memory decode enables. A dword-wide configuration port lets firmware read and write these registers. Each slot's kind, size and prefetchability are fixed by parameters. A slot can be unused, an I/O window, a 32-bit memory window, or the low half of a 64-bit memory window. A 64-bit window uses the next slot for its upper address bits. Address bits below a window's size are hardwired, so firmware can write all ones and read back the value to learn the size.

On the transaction side the block takes an address and an I/O-or-memory flag. It reports, combinationally, whether the function claims that access, which region matched, and the byte offset into that region. Along with the six slots and the ROM window, the block can claim the fixed legacy display windows. These are memory 0xA0000–0xBFFFF and I/O ports 0x3B0–0x3BB and 0x3C0–0x3DF, and they do not depend on any base register.

The block has no sequential control beyond its registers. It contains no state machine, so there are no states or transitions to name.

Top module: `bar_decoder`

## Requirements
- R1: After reset, both command enables are 0, every stored base bit is 0, and no access of either space is claimed.
- R2: A memory slot reads back bit 0 = 0. Bits 2:1 read 00 for a 32-bit window and 10 for a 64-bit window. Bit 3 reads the prefetchable parameter. Writes do not change any of these bits.
- R3: An I/O slot reads back bit 0 = 1 and bit 1 = 0, and writes do not change either bit.
- R4: Base bits below the window size read 0 and ignore writes. Writing 0xFFFFFFFF to a slot and reading it back returns the size mask OR-ed with the fixed low bits.
- R5: The slot after a 64-bit window stores address bits 63:32 with all 32 bits writable. A memory hit on the window needs the upper address bits to equal that slot.
- R6: Unused slots and every configuration dword outside the command word (dword 1), the slots (dwords 4–9) and the ROM register (dword 12) read as 0 and ignore writes.
- R7: Configuration writes change only the bytes whose enable bit is set. Enable bit n covers data bits 8n+7:8n.
- R8: A memory access hits a memory slot when its address bits above the size equal the stored base. The hit reports the slot index (0–5) as the region and the address modulo the size as the offset. A 32-bit window also needs address bits 63:32 to be zero.
- R9: An I/O access with address bits 63:32 zero hits an I/O slot when its bits above the size equal the base. The region and offset are reported as in R8. Memory accesses never hit I/O slots, and I/O accesses never hit memory slots.
- R10: Command-word bit 0 enables I/O decode and bit 1 enables memory decode. With an enable at 0, no access of that space is claimed.
- R11: The ROM register at dword 12 has its enable in bit 0 and hardwired-zero bits 10:1. Its base bits below the ROM size are probed as in R4. It is claimed as region 6 only when both the ROM enable and the memory enable are 1.
- R12: With legacy support on, the block claims memory 0xA0000–0xBFFFF and I/O ports 0x3B0–0x3BB and 0x3C0–0x3DF as region 7, each gated by its space's enable. The offset is measured from the start of the matching window.
- R13: At most one region is reported, in this priority order: legacy windows, then the lowest-numbered slot, then the ROM. On a miss, region and offset are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe, one dword per cycle |
| cfg_dw_addr | input | 6 | Configuration dword index (byte offset / 4) |
| cfg_be | input | 4 | Byte enables for writes |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read data for cfg_dw_addr, combinational |
| txn_addr | input | 64 | Address of the incoming access |
| txn_is_io | input | 1 | 1 for an I/O access, 0 for a memory access |
| hit | output | 1 | The function claims the access |
| hit_region | output | 3 | Slot index 0–5, 6 for ROM, 7 for legacy window |
| hit_offset | output | 64 | Byte offset inside the matched region |

## Verification
The decoder is probed with addresses at both edges of each window and one step past the upper edge. This separates correct size masking from off-by-one or wrongly sized comparisons. The same addresses are sent with the I/O flag flipped, and with high address bits set, to confirm that space and width are checked. Deliberately overlapping windows (a slot covering the legacy range, two slots sharing space, the ROM inside a slot) show the priority order. All-ones writes, partial byte writes and writes to unused dwords show which bits are writable.

// File: rtl/bar_cfg_pkg.sv
package bar_cfg_pkg;

    localparam int NSLOT = 6;

    // slot kinds
    localparam logic [2:0] KIND_NONE = 3'd0;
    localparam logic [2:0] KIND_IO   = 3'd1;
    localparam logic [2:0] KIND_M32  = 3'd2;
    localparam logic [2:0] KIND_M64  = 3'd3;
    localparam logic [2:0] KIND_HI   = 3'd4;

    // configuration dword indices
    localparam logic [5:0] DW_CMD   = 6'h01;
    localparam logic [5:0] DW_SLOT0 = 6'h04;
    localparam logic [5:0] DW_ROM   = 6'h0C;

    localparam logic [2:0] REGION_ROM = 3'd6;
    localparam logic [2:0] REGION_VGA = 3'd7;

    // ones at and above bit sz
    function automatic logic [63:0] size_mask(input logic [5:0] sz);
        return ~((64'd1 << sz) - 64'd1);
    endfunction

    function automatic logic [31:0] slot_wmask(input logic [2:0] kind,
                                               input logic [5:0] sz,
                                               input logic [5:0] prev_sz);
        logic [63:0] m;
        logic [63:0] p;
        m = size_mask(sz);
        p = size_mask(prev_sz);
        case (kind)
            KIND_IO:            return m[31:0] & 32'hFFFF_FFFC;
            KIND_M32, KIND_M64: return m[31:0] & 32'hFFFF_FFF0;
            KIND_HI:            return p[63:32];
            default:            return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] slot_fixed(input logic [2:0] kind, input logic pf);
        case (kind)
            KIND_IO:  return 32'h1;
            KIND_M32: return {28'h0, pf, 3'b000};
            KIND_M64: return {28'h0, pf, 3'b100};
            default:  return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] rom_wmask(input logic [5:0] sz);
        logic [63:0] m;
        m = size_mask(sz);
        return (m[31:0] & 32'hFFFF_F800) | 32'h1;
    endfunction

    function automatic logic [31:0] byte_mask(input logic [3:0] be);
        logic [31:0] m;
        for (int b = 0; b < 4; b++) m[8*b +: 8] = {8{be[b]}};
        return m;
    endfunction

endpackage

// File: rtl/bar_cfg_bank.sv
module bar_cfg_bank
    import bar_cfg_pkg::*;
#(
    parameter logic [NSLOT-1:0][2:0] SLOT_KIND = '0,
    parameter logic [NSLOT-1:0][5:0] SLOT_SZ   = '0,
    parameter logic [NSLOT-1:0]      SLOT_PF   = '0,
    parameter logic [5:0]            ROM_SZ    = 6'd17
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [5:0]                  dw_addr,
    input  logic [3:0]                  be,
    input  logic [31:0]                 wdata,
    output logic [31:0]                 rdata,
    output logic [NSLOT-1:0][31:0]      slot_base,
    output logic [31:0]                 rom_base,
    output logic                        io_en,
    output logic                        mem_en
);

    localparam logic [31:0] ROM_WMASK = rom_wmask(ROM_SZ);

    logic [31:0]            bmask;
    logic [NSLOT-1:0][31:0] slot_rd;

    assign bmask = byte_mask(be);

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        localparam logic [31:0] WMASK =
            slot_wmask(SLOT_KIND[i], SLOT_SZ[i], SLOT_SZ[(i > 0) ? (i - 1) : 0]);
        localparam logic [31:0] FIXED = slot_fixed(SLOT_KIND[i], SLOT_PF[i]);
        logic [31:0] base_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                base_q <= '0;
            else if (wr_en && dw_addr == DW_SLOT0 + 6'(i))
                base_q <= ((base_q & ~bmask) | (wdata & bmask)) & WMASK;
        end

        assign slot_base[i] = base_q;
        assign slot_rd[i]   = base_q | FIXED;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rom_base <= '0;
        else if (wr_en && dw_addr == DW_ROM)
            rom_base <= ((rom_base & ~bmask) | (wdata & bmask)) & ROM_WMASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            io_en  <= 1'b0;
            mem_en <= 1'b0;
        end else if (wr_en && dw_addr == DW_CMD && be[0]) begin
            io_en  <= wdata[0];
            mem_en <= wdata[1];
        end
    end

    always_comb begin
        rdata = '0;
        if (dw_addr == DW_CMD)
            rdata = {30'h0, mem_en, io_en};
        else if (dw_addr == DW_ROM)
            rdata = rom_base;
        else
            for (int k = 0; k < NSLOT; k++)
                if (dw_addr == DW_SLOT0 + 6'(k)) rdata = slot_rd[k];
    end

endmodule

// File: rtl/bar_match.sv
module bar_match
    import bar_cfg_pkg::*;
#(
    parameter logic [NSLOT-1:0][2:0] SLOT_KIND = '0,
    parameter logic [NSLOT-1:0][5:0] SLOT_SZ   = '0,
    parameter logic [5:0]            ROM_SZ    = 6'd17,
    parameter bit                    VGA_EN    = 1'b1
) (
    input  logic [NSLOT-1:0][31:0] slot_base,
    input  logic [31:0]            rom_base,
    input  logic                   io_en,
    input  logic                   mem_en,
    input  logic [63:0]            txn_addr,
    input  logic                   txn_is_io,
    output logic                   hit,
    output logic [2:0]             hit_region,
    output logic [63:0]            hit_offset
);

    localparam logic [63:0] ROM_M = size_mask(ROM_SZ);

    logic                   upper_zero;
    logic [NSLOT-1:0]       s_hit;
    logic [NSLOT-1:0][63:0] s_off;
    logic                   rom_hit;
    logic                   vga_mem, vga_io_lo, vga_io_hi;

    assign upper_zero = (txn_addr[63:32] == 32'h0);

    for (genvar i = 0; i < NSLOT; i++) begin : g_cmp
        localparam logic [63:0] M = size_mask(SLOT_SZ[i]);
        localparam int J = (i < NSLOT - 1) ? (i + 1) : i;
        if (SLOT_KIND[i] == KIND_IO) begin : g_io
            assign s_hit[i] = io_en && txn_is_io && upper_zero &&
                              (((txn_addr ^ {32'h0, slot_base[i]}) & M) == 64'h0);
        end else if (SLOT_KIND[i] == KIND_M32) begin : g_m32
            assign s_hit[i] = mem_en && !txn_is_io && upper_zero &&
                              (((txn_addr ^ {32'h0, slot_base[i]}) & M) == 64'h0);
        end else if (SLOT_KIND[i] == KIND_M64) begin : g_m64
            assign s_hit[i] = mem_en && !txn_is_io &&
                              (((txn_addr ^ {slot_base[J], slot_base[i]}) & M) == 64'h0);
        end else begin : g_none
            assign s_hit[i] = 1'b0;
        end
        assign s_off[i] = txn_addr & ~M;
    end

    assign rom_hit = mem_en && !txn_is_io && rom_base[0] && upper_zero &&
                     (((txn_addr ^ {32'h0, rom_base & 32'hFFFF_FFFE}) & ROM_M) == 64'h0);

    assign vga_mem   = VGA_EN && mem_en && !txn_is_io &&
                       txn_addr >= 64'hA_0000 && txn_addr <= 64'hB_FFFF;
    assign vga_io_lo = VGA_EN && io_en && txn_is_io &&
                       txn_addr >= 64'h3B0 && txn_addr <= 64'h3BB;
    assign vga_io_hi = VGA_EN && io_en && txn_is_io &&
                       txn_addr >= 64'h3C0 && txn_addr <= 64'h3DF;

    always_comb begin
        hit        = 1'b0;
        hit_region = 3'd0;
        hit_offset = 64'h0;
        if (vga_mem) begin
            hit = 1'b1; hit_region = REGION_VGA; hit_offset = txn_addr - 64'hA_0000;
        end else if (vga_io_lo) begin
            hit = 1'b1; hit_region = REGION_VGA; hit_offset = txn_addr - 64'h3B0;
        end else if (vga_io_hi) begin
            hit = 1'b1; hit_region = REGION_VGA; hit_offset = txn_addr - 64'h3C0;
        end else begin
            for (int k = 0; k < NSLOT; k++) begin
                if (!hit && s_hit[k]) begin
                    hit = 1'b1; hit_region = 3'(k); hit_offset = s_off[k];
                end
            end
            if (!hit && rom_hit) begin
                hit = 1'b1; hit_region = REGION_ROM; hit_offset = txn_addr & ~ROM_M;
            end
        end
    end

endmodule

// File: rtl/bar_decoder.sv
module bar_decoder
    import bar_cfg_pkg::*;
#(
    // slot 5 .. slot 0
    parameter logic [NSLOT-1:0][2:0] SLOT_KIND = {KIND_M32, KIND_IO, KIND_HI,
                                                  KIND_M64, KIND_HI, KIND_M64},
    parameter logic [NSLOT-1:0][5:0] SLOT_SZ   = {6'd19, 6'd8, 6'd0,
                                                  6'd21, 6'd0, 6'd28},
    parameter logic [NSLOT-1:0]      SLOT_PF   = 6'b000001,
    parameter logic [5:0]            ROM_SZ    = 6'd17,
    parameter bit                    VGA_EN    = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr_en,
    input  logic [5:0]  cfg_dw_addr,
    input  logic [3:0]  cfg_be,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic [63:0] txn_addr,
    input  logic        txn_is_io,
    output logic        hit,
    output logic [2:0]  hit_region,
    output logic [63:0] hit_offset
);

    logic [NSLOT-1:0][31:0] slot_base_w;
    logic [31:0]            rom_base_w;
    logic                   io_en_w;
    logic                   mem_en_w;

    bar_cfg_bank #(
        .SLOT_KIND (SLOT_KIND),
        .SLOT_SZ   (SLOT_SZ),
        .SLOT_PF   (SLOT_PF),
        .ROM_SZ    (ROM_SZ)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_wr_en),
        .dw_addr   (cfg_dw_addr),
        .be        (cfg_be),
        .wdata     (cfg_wdata),
        .rdata     (cfg_rdata),
        .slot_base (slot_base_w),
        .rom_base  (rom_base_w),
        .io_en     (io_en_w),
        .mem_en    (mem_en_w)
    );

    bar_match #(
        .SLOT_KIND (SLOT_KIND),
        .SLOT_SZ   (SLOT_SZ),
        .ROM_SZ    (ROM_SZ),
        .VGA_EN    (VGA_EN)
    ) u_match (
        .slot_base  (slot_base_w),
        .rom_base   (rom_base_w),
        .io_en      (io_en_w),
        .mem_en     (mem_en_w),
        .txn_addr   (txn_addr),
        .txn_is_io  (txn_is_io),
        .hit        (hit),
        .hit_region (hit_region),
        .hit_offset (hit_offset)
    );

endmodule

// File: rtl/bar_decoder_chk.sv
module bar_decoder_chk #(
    parameter bit VGA_EN = 1'b1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_wr_en,
    input logic [5:0]  cfg_dw_addr,
    input logic        cmd_be0,
    input logic [1:0]  cmd_wdata,
    input logic [31:0] cfg_rdata,
    input logic [63:0] txn_addr,
    input logic        txn_is_io,
    input logic        hit,
    input logic [2:0]  hit_region,
    input logic [63:0] hit_offset,
    input logic        io_en,
    input logic        mem_en,
    input logic        rom_en
);

    logic dw_known;
    assign dw_known = (cfg_dw_addr == 6'h01) ||
                      (cfg_dw_addr >= 6'h04 && cfg_dw_addr <= 6'h09) ||
                      (cfg_dw_addr == 6'h0C);

    // R10 and R1: memory claims need the memory enable
    p_mem_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !txn_is_io) |-> mem_en);

    // R10: I/O claims need the I/O enable
    p_io_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && txn_is_io) |-> io_en);

    // R10: a command write lands in the enables on the next cycle
    p_cmd_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_dw_addr == 6'h01 && cmd_be0) |=>
        (io_en == $past(cmd_wdata[0]) && mem_en == $past(cmd_wdata[1])));

    // R13: a miss carries zero region and offset
    p_miss_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (hit_region == 3'd0 && hit_offset == 64'h0));

    // R11: ROM claims need both enables
    p_rom_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && hit_region == 3'd6) |-> (rom_en && mem_en));

    // R6: undefined dwords read zero
    p_unused_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !dw_known |-> (cfg_rdata == 32'h0));

    // R12: legacy memory window always wins when decoding is on
    p_vga_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (VGA_EN && mem_en && !txn_is_io &&
         txn_addr >= 64'hA_0000 && txn_addr <= 64'hB_FFFF) |->
        (hit && hit_region == 3'd7));

endmodule

bind bar_decoder bar_decoder_chk #(.VGA_EN(VGA_EN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_dw_addr (cfg_dw_addr),
    .cmd_be0     (cfg_be[0]),
    .cmd_wdata   (cfg_wdata[1:0]),
    .cfg_rdata   (cfg_rdata),
    .txn_addr    (txn_addr),
    .txn_is_io   (txn_is_io),
    .hit         (hit),
    .hit_region  (hit_region),
    .hit_offset  (hit_offset),
    .io_en       (io_en_w),
    .mem_en      (mem_en_w),
    .rom_en      (rom_base_w[0])
);

// File: tb/tb_bar_decoder.sv
module tb_bar_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [5:0]  cfg_dw_addr = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [63:0] txn_addr = '0;
    logic        txn_is_io = 1'b0;
    logic        hit;
    logic [2:0]  hit_region;
    logic [63:0] hit_offset;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;   // 250 MHz

    bar_decoder dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_dw_addr(cfg_dw_addr),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .txn_addr(txn_addr), .txn_is_io(txn_is_io),
        .hit(hit), .hit_region(hit_region), .hit_offset(hit_offset)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic cfg_wr(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_dw_addr = a; cfg_be = be; cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0; cfg_be = '0;
    endtask

    task automatic cfg_expect(input string req, input logic [5:0] a, input logic [31:0] exp);
        @(negedge clk);
        cfg_dw_addr = a;
        #1;
        check(req, $sformatf("read dw %0h", a), {32'h0, cfg_rdata}, {32'h0, exp});
    endtask

    task automatic probe(input string req, input logic [63:0] a, input logic io,
                         input logic eh, input logic [2:0] er, input logic [63:0] eo);
        @(negedge clk);
        txn_addr = a; txn_is_io = io;
        #1;
        check(req, $sformatf("hit @%h io%0d", a, io), {63'h0, hit}, {63'h0, eh});
        check(req, $sformatf("region @%h", a), {61'h0, hit_region}, {61'h0, er});
        check(req, $sformatf("offset @%h", a), hit_offset, eo);
    endtask

    task automatic t_reset();
        cfg_expect("R1", 6'h01, 32'h0);
        cfg_expect("R1", 6'h05, 32'h0);
        cfg_expect("R1", 6'h0C, 32'h0);
        probe("R1", 64'h0, 1'b0, 1'b0, 3'd0, 64'h0);
        probe("R1", 64'hA_0000, 1'b0, 1'b0, 3'd0, 64'h0);
        probe("R1", 64'h3C0, 1'b1, 1'b0, 3'd0, 64'h0);
    endtask

    task automatic t_encoding();
        cfg_expect("R2", 6'h04, 32'h0000_000C);
        cfg_expect("R2", 6'h06, 32'h0000_0004);
        cfg_expect("R2", 6'h09, 32'h0000_0000);
        cfg_expect("R3", 6'h08, 32'h0000_0001);
        cfg_wr(6'h08, 4'hF, 32'h0000_0002);
        cfg_expect("R3", 6'h08, 32'h0000_0001);
    endtask

    task automatic t_sizing();
        for (int s = 4; s <= 9; s++) cfg_wr(6'(s), 4'hF, 32'hFFFF_FFFF);
        cfg_wr(6'h0C, 4'hF, 32'hFFFF_FFFF);
        cfg_expect("R4", 6'h04, 32'hF000_000C);
        cfg_expect("R5", 6'h05, 32'hFFFF_FFFF);
        cfg_expect("R4", 6'h06, 32'hFFE0_0004);
        cfg_expect("R5", 6'h07, 32'hFFFF_FFFF);
        cfg_expect("R4", 6'h08, 32'hFFFF_FF01);
        cfg_expect("R4", 6'h09, 32'hFFF8_0000);
        cfg_expect("R11", 6'h0C, 32'hFFFE_0001);
    endtask

    task automatic t_unused();
        cfg_wr(6'h0A, 4'hF, 32'hFFFF_FFFF);
        cfg_expect("R6", 6'h0A, 32'h0);
        cfg_wr(6'h00, 4'hF, 32'hFFFF_FFFF);
        cfg_expect("R6", 6'h00, 32'h0);
        cfg_expect("R6", 6'h3F, 32'h0);
    endtask

    task automatic t_program();
        cfg_wr(6'h04, 4'hF, 32'hD000_0000);
        cfg_wr(6'h05, 4'hF, 32'h0);
        cfg_wr(6'h06, 4'hF, 32'hE000_0000);
        cfg_wr(6'h07, 4'hF, 32'h0);
        cfg_wr(6'h08, 4'hF, 32'h0000_E000);
        cfg_wr(6'h09, 4'hF, 32'hEFD0_0000);
        cfg_wr(6'h0C, 4'hF, 32'hC000_0001);
        cfg_wr(6'h01, 4'h1, 32'h3);
        cfg_expect("R10", 6'h01, 32'h3);
    endtask

    task automatic t_bytes();
        cfg_wr(6'h09, 4'b1000, 32'h1234_5678);
        cfg_expect("R7", 6'h09, 32'h12D0_0000);
        cfg_wr(6'h09, 4'b1000, 32'hEF00_0000);
        cfg_expect("R7", 6'h09, 32'hEFD0_0000);
        cfg_wr(6'h01, 4'b0010, 32'h0);
        cfg_expect("R7", 6'h01, 32'h3);
    endtask

    task automatic t_mem();
        probe("R8", 64'hD000_1234, 1'b0, 1'b1, 3'd0, 64'h1234);
        probe("R8", 64'hDFFF_FFFF, 1'b0, 1'b1, 3'd0, 64'h0FFF_FFFF);
        probe("R8", 64'hE000_0000, 1'b0, 1'b1, 3'd2, 64'h0);
        probe("R8", 64'hE01F_FFFF, 1'b0, 1'b1, 3'd2, 64'h1F_FFFF);
        probe("R8", 64'hE020_0000, 1'b0, 1'b0, 3'd0, 64'h0);
        probe("R8", 64'hEFD7_FFFF, 1'b0, 1'b1, 3'd5, 64'h7_FFFF);
        probe("R8", 64'hEFD8_0000, 1'b0, 1'b0, 3'd0, 64'h0);
        probe("R8", 64'h1_EFD0_0000, 1'b0, 1'b0, 3'd0, 64'h0);
        probe("R9", 64'hD000_1234, 1'b1, 1'b0, 3'd0, 64'h0);
    endtask

    task automatic t_io();
        probe("R9", 64'hE010, 1'b1, 1'b1, 3'd4, 64'h10);
        probe("R9", 64'hE0FF, 1'b1, 1'b1, 3'd4, 64'hFF);
        probe("R9", 64'hE100, 1'b1, 1'b0, 3'd0, 64'h0);
        probe("R9", 64'hE010, 1'b0, 1'b0, 3'd0, 64'h0);
        probe("R9", 64'h1_0000_E010, 1'b1, 1'b0, 3'd0, 64'h0);
    endtask

    task automatic t_wide();
        cfg_wr(6'h05, 4'hF, 32'h0000_0001);
        probe("R5", 64'h1_D000_0040, 1'b0, 1'b1, 3'd0, 64'h40);
        probe("R5", 64'hD000_0040, 1'b0, 1'b0, 3'd0, 64'h0);
        cfg_wr(6'h05, 4'hF, 32'h0);
        probe("R5", 64'hD000_0040, 1'b0, 1'b1, 3'd0, 64'h40);
    endtask

    task automatic t_enables();
        cfg_wr(6'h01, 4'h1, 32'h1);
        probe("R10", 64'hD000_0000, 1'b0, 1'b0, 3'd0, 64'h0);
        probe("R10", 64'hE010, 1'b1, 1'b1, 3'd4, 64'h10);
        cfg_wr(6'h01, 4'h1, 32'h2);
        probe("R10", 64'hE010, 1'b1, 1'b0, 3'd0, 64'h0);
        probe("R10", 64'hD000_0000, 1'b0, 1'b1, 3'd0, 64'h0);
        cfg_wr(6'h01, 4'h1, 32'h3);
    endtask

    task automatic t_rom();
        probe("R11", 64'hC001_0000, 1'b0, 1'b1, 3'd6, 64'h1_0000);
        probe("R11", 64'hC002_0000, 1'b0, 1'b0, 3'd0, 64'h0);
        cfg_wr(6'h0C, 4'h1, 32'h0);
        probe("R11", 64'hC001_0000, 1'b0, 1'b0, 3'd0, 64'h0);
        cfg_expect("R11", 6'h0C, 32'hC000_0000);
        cfg_wr(6'h0C, 4'h1, 32'h1);
        cfg_wr(6'h01, 4'h1, 32'h1);
        probe("R11", 64'hC001_0000, 1'b0, 1'b0, 3'd0, 64'h0);
        cfg_wr(6'h01, 4'h1, 32'h3);
    endtask

    task automatic t_vga();
        probe("R12", 64'hA_1000, 1'b0, 1'b1, 3'd7, 64'h1000);
        probe("R12", 64'hB_FFFF, 1'b0, 1'b1, 3'd7, 64'h1_FFFF);
        probe("R12", 64'hC_0000, 1'b0, 1'b0, 3'd0, 64'h0);
        probe("R12", 64'h3B5, 1'b1, 1'b1, 3'd7, 64'h5);
        probe("R12", 64'h3BC, 1'b1, 1'b0, 3'd0, 64'h0);
        probe("R12", 64'h3C0, 1'b1, 1'b1, 3'd7, 64'h0);
        probe("R12", 64'h3DF, 1'b1, 1'b1, 3'd7, 64'h1F);
        probe("R12", 64'h3E0, 1'b1, 1'b0, 3'd0, 64'h0);
        probe("R12", 64'h3C0, 1'b0, 1'b0, 3'd0, 64'h0);
        cfg_wr(6'h01, 4'h1, 32'h2);
        probe("R12", 64'h3C0, 1'b1, 1'b0, 3'd0, 64'h0);
        cfg_wr(6'h01, 4'h1, 32'h3);
    endtask

    task automatic t_priority();
        cfg_wr(6'h09, 4'hF, 32'h0008_0000);
        probe("R13", 64'hA_0000, 1'b0, 1'b1, 3'd7, 64'h0);
        probe("R13", 64'h8_0010, 1'b0, 1'b1, 3'd5, 64'h10);
        probe("R13", 64'hC_0000, 1'b0, 1'b1, 3'd5, 64'h4_0000);
        cfg_wr(6'h09, 4'hF, 32'hEFD0_0000);
        cfg_wr(6'h06, 4'hF, 32'hEFC0_0000);
        probe("R13", 64'hEFD0_0010, 1'b0, 1'b1, 3'd2, 64'h10_0010);
        cfg_wr(6'h06, 4'hF, 32'hE000_0000);
        cfg_wr(6'h0C, 4'hF, 32'hEFD0_0001);
        probe("R13", 64'hEFD0_0020, 1'b0, 1'b1, 3'd5, 64'h20);
    endtask

    initial begin
        #800000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_encoding();
        t_sizing();
        t_unused();
        t_program();
        t_bytes();
        t_mem();
        t_io();
        t_wide();
        t_enables();
        t_rom();
        t_vga();
        t_priority();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule